// File: doc/BRIEF.md
# Waveguide Delay Loop Sequencer

This block runs the delay loop of a plucked-string waveguide on one single-port synchronous RAM. The whole RAM address space is the loop. One circular pointer marks both the oldest sample and the slot that is rewritten. Each sample tick starts a short fixed sequence of steps:
- read a pickup tap at the pointer plus an offset, for audio output;
- read the oldest loop sample into the input register of an external feedback filter;
- write the filter's current output back over that slot;
- step the pointer by one.

All RAM accesses fall in separate cycles, so plain single-ported memory is enough. The pickup offset moves only the tap. It never changes the loop length and is never folded back into the pointer. The offset is captured once at the start of each sequence. A tick that arrives while a sequence is running is held and served right after that sequence ends.

Top module: `wgLoopSeq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the pointer, `tapOut` and `filtIn` to zero and puts the sequencer in idle. After reset `ramWe` is low, and the first write of the next sequence goes to address 0.
- R2: A sequence starts only on a `sampleTick` pulse. While idle with no tick pending, `ramWe` stays low. Each served tick produces exactly one RAM write.
- R3: The tap is read at address (pointer + latched offset) modulo 2^ADDR_W. The data read there appears on `tapOut` and holds until the next sequence's tap capture.
- R4: The loop sample at the unmodified pointer is captured into `filtIn`. On that same clock edge, `filtOut` is written to the pointer address. This is the only cycle with `ramWe` high, and `ramWrData` equals `filtOut` during it.
- R5: The pointer advances by exactly one per sequence in a final step of its own. It wraps from 2^ADDR_W-1 to 0, so successive write addresses are consecutive modulo 2^ADDR_W regardless of the offset.
- R6: `pickupOffset` is sampled on the edge that starts a sequence. Changes to it later in the same sequence have no effect on that sequence's tap address.
- R7: A tick that arrives while a sequence is running is held pending and starts one further sequence after the current one returns to idle. Several ticks during one sequence are served as a single further sequence.
- R8: The RAM has one clock of read latency. The sequence steps through these cycles in order:
  1. tap address;
  2. tap capture;
  3. loop address;
  4. loop capture and write;
  5. pointer advance.

  `ramWe` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleTick | input | 1 | One-cycle pulse requesting a sample sequence |
| pickupOffset | input | ADDR_W | Tap distance from the pointer |
| filtOut | input | DATA_W | Output of the external feedback filter, written into the loop |
| filtIn | output | DATA_W | Registered loop sample fed to the filter input |
| ramAddr | output | ADDR_W | RAM address |
| ramWrData | output | DATA_W | RAM write data |
| ramWe | output | 1 | RAM write enable |
| ramRdData | input | DATA_W | RAM read data, valid one clock after the address |
| tapOut | output | DATA_W | Registered pickup tap sample |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=12, so the loop is only sixteen slots long. A run of a few dozen samples therefore wraps the pointer several times. The tap sum overflows for most offsets, and the offset equal to zero makes the tap and the loop read hit the same slot. A bench-side RAM model with registered reads, and a shadow copy of its contents, give expected tap and filter-input values that depend on the written history. This exposes any misordered read, write or pointer step.

// File: rtl/wgLoopSeqPkg.sv
package wgLoopSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_TAP_ADDR = 3'd1,
    ST_TAP_CAP  = 3'd2,
    ST_LP_ADDR  = 3'd3,
    ST_LP_CAP   = 3'd4,
    ST_ADVANCE  = 3'd5
  } seqState_t;

  typedef struct packed {
    logic latchOffset;
    logic selTap;
    logic captureTap;
    logic captureLoop;
    logic writeLoop;
    logic advance;
  } seqStrobes_t;

endpackage

// File: rtl/wgLoopSeqCtrl.sv
module wgLoopSeqCtrl
  import wgLoopSeqPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleTick,
  output seqStrobes_t strobes
);

  seqState_t state;
  seqState_t stateNext;
  logic      pending;
  logic      start;

  assign start = (state == ST_IDLE) && (sampleTick || pending);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (start) stateNext = ST_TAP_ADDR;
      ST_TAP_ADDR: stateNext = ST_TAP_CAP;
      ST_TAP_CAP:  stateNext = ST_LP_ADDR;
      ST_LP_ADDR:  stateNext = ST_LP_CAP;
      ST_LP_CAP:   stateNext = ST_ADVANCE;
      ST_ADVANCE:  stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      state <= stateNext;
      if (start)
        pending <= 1'b0;
      else if (sampleTick && (state != ST_IDLE))
        pending <= 1'b1;
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.latchOffset = start;
    strobes.selTap      = (state == ST_TAP_ADDR);
    strobes.captureTap  = (state == ST_TAP_CAP);
    strobes.captureLoop = (state == ST_LP_CAP);
    strobes.writeLoop   = (state == ST_LP_CAP);
    strobes.advance     = (state == ST_ADVANCE);
  end

endmodule

// File: rtl/wgLoopSeqDatapath.sv
module wgLoopSeqDatapath
  import wgLoopSeqPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] pickupOffset,
  input  logic [DATA_W-1:0] filtOut,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              ramWe,
  output logic [DATA_W-1:0] tapOut,
  output logic [DATA_W-1:0] filtIn
);

  localparam logic [ADDR_W-1:0] PTR_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] loopPtr;
  logic [ADDR_W-1:0] offLatch;
  logic [ADDR_W-1:0] tapAddr;

  // binary overflow performs the wrap of both pointer and tap
  assign tapAddr   = loopPtr + offLatch;
  assign ramAddr   = strobes.selTap ? tapAddr : loopPtr;
  assign ramWe     = strobes.writeLoop;
  assign ramWrData = filtOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      loopPtr  <= '0;
      offLatch <= '0;
      tapOut   <= '0;
      filtIn   <= '0;
    end else begin
      if (strobes.latchOffset) offLatch <= pickupOffset;
      if (strobes.captureTap)  tapOut   <= ramRdData;
      if (strobes.captureLoop) filtIn   <= ramRdData;
      if (strobes.advance)     loopPtr  <= loopPtr + PTR_STEP;
    end
  end

endmodule

// File: rtl/wgLoopSeq.sv
module wgLoopSeq
  import wgLoopSeqPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleTick,
  input  logic [ADDR_W-1:0] pickupOffset,
  input  logic [DATA_W-1:0] filtOut,
  output logic [DATA_W-1:0] filtIn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              ramWe,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] tapOut
);

  seqStrobes_t strobes;

  wgLoopSeqCtrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .sampleTick (sampleTick),
    .strobes    (strobes)
  );

  wgLoopSeqDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) uPath (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .pickupOffset (pickupOffset),
    .filtOut      (filtOut),
    .ramRdData    (ramRdData),
    .ramAddr      (ramAddr),
    .ramWrData    (ramWrData),
    .ramWe        (ramWe),
    .tapOut       (tapOut),
    .filtIn       (filtIn)
  );

endmodule

// File: rtl/wgLoopSeqChk.sv
module wgLoopSeqChk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] filtOut,
  input logic [DATA_W-1:0] filtIn,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [DATA_W-1:0] ramWrData,
  input logic              ramWe,
  input logic [DATA_W-1:0] tapOut
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              wasRst    = 1'b0;
  logic              haveWrite = 1'b0;
  logic [ADDR_W-1:0] lastAddr  = '0;
  logic [ADDR_W-1:0] nextAddr;

  assign nextAddr = haveWrite ? (lastAddr + ONE) : '0;

  always_ff @(posedge clk) begin
    wasRst <= rst;
    if (rst) begin
      haveWrite <= 1'b0;
      lastAddr  <= '0;
    end else if (ramWe) begin
      haveWrite <= 1'b1;
      lastAddr  <= ramAddr;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    wasRst |-> (tapOut == '0) && (filtIn == '0) && !ramWe);

  p_write_data_r4: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> (ramWrData == filtOut));

  p_filtin_edge_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(filtIn) |-> $past(ramWe));

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> (ramAddr == nextAddr));

  p_single_write_r8: assert property (@(posedge clk) disable iff (rst)
    ramWe |=> !ramWe);

endmodule

bind wgLoopSeq wgLoopSeqChk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .filtOut   (filtOut),
  .filtIn    (filtIn),
  .ramAddr   (ramAddr),
  .ramWrData (ramWrData),
  .ramWe     (ramWe),
  .tapOut    (tapOut)
);

// File: tb/tb_wgLoopSeq.sv
`timescale 1ns/1ps
module tb_wgLoopSeq;

  localparam int AW = 4;
  localparam int DW = 12;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sampleTick = 1'b0;
  logic [AW-1:0] pickupOffset = '0;
  logic [DW-1:0] filtOut = '0;
  logic [DW-1:0] filtIn;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWrData;
  logic          ramWe;
  logic [DW-1:0] ramRdData = '0;
  logic [DW-1:0] tapOut;

  always #2.5 clk = ~clk;

  wgLoopSeq #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .pickupOffset(pickupOffset),
    .filtOut(filtOut), .filtIn(filtIn), .ramAddr(ramAddr), .ramWrData(ramWrData),
    .ramWe(ramWe), .ramRdData(ramRdData), .tapOut(tapOut)
  );

  // single-port RAM model, registered read of the old contents
  logic [DW-1:0] mem [N];
  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWrData;
    ramRdData <= mem[ramAddr];
  end

  int checks = 0;
  int fails  = 0;
  int writeCount = 0;
  int expCount = 0;

  int shadow [N];
  int shPtr = 0;

  int qAddr[$];
  int qData[$];
  int qTap[$];
  int qFin[$];

  int     pendTap, pendFin;
  logic   chkPending = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // driver side: expected result of one served sequence
  task automatic pushExp(input int off, input int fval);
    qTap.push_back(shadow[(shPtr + off) % N]);
    qFin.push_back(shadow[shPtr]);
    qAddr.push_back(shPtr);
    qData.push_back(fval);
    shadow[shPtr] = fval;
    shPtr = (shPtr + 1) % N;
    expCount++;
  endtask

  task automatic sendSample(input int off, input int fval, input bit moveOffset);
    @(negedge clk);
    pickupOffset = AW'(off);
    filtOut      = DW'(fval);
    sampleTick   = 1'b1;
    pushExp(off, fval);
    @(negedge clk);
    sampleTick = 1'b0;
    if (moveOffset) pickupOffset = AW'(off + 7);   // R6 late change
    repeat (7) @(negedge clk);
  endtask

  // monitor: write cycle, then registered results one cycle later
  always @(negedge clk) begin
    if (chkPending) begin
      check(tapOut == DW'(pendTap), "R3 tap sample", int'(tapOut), pendTap);
      check(filtIn == DW'(pendFin), "R4 filter input", int'(filtIn), pendFin);
      chkPending = 1'b0;
    end
    if (!rst && ramWe) begin
      writeCount++;
      if (qAddr.size() == 0) begin
        check(1'b0, "R2 unexpected write", int'(ramAddr), -1);
      end else begin
        int ea, ed;
        ea = qAddr.pop_front();
        ed = qData.pop_front();
        pendTap = qTap.pop_front();
        pendFin = qFin.pop_front();
        check(ramAddr == AW'(ea), "R5 write address", int'(ramAddr), ea);
        check(ramWrData == DW'(ed), "R4 write data", int'(ramWrData), ed);
        chkPending = 1'b1;
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mem[i]    = DW'(i * 37 + 16'h105);
      shadow[i] = (i * 37 + 16'h105) & ((1 << DW) - 1);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tapOut == '0, "R1 tapOut after reset", int'(tapOut), 0);
    check(filtIn == '0, "R1 filtIn after reset", int'(filtIn), 0);
    begin
      int idleWrites = 0;
      for (int i = 0; i < 10; i++) begin
        if (ramWe) idleWrites++;
        @(negedge clk);
      end
      check(idleWrites == 0, "R2 no write while idle", idleWrites, 0);
    end

    // main loop: varied offsets across several wraps (R3, R5)
    for (int s = 0; s < 40; s++) begin
      sendSample((s * 5 + (s / 3)) % N, (s * 91 + 3) % (1 << DW), 1'b0);
    end
    sendSample(0, 12'h0AA, 1'b0);
    sendSample(N - 1, 12'h0BB, 1'b0);

    // offset moved after start (R6)
    sendSample(3, 12'h123, 1'b1);
    sendSample(12, 12'h456, 1'b1);

    // ticks during a sequence collapse into one pending (R7)
    @(negedge clk);
    pickupOffset = AW'(2);
    filtOut      = DW'(12'h777);
    sampleTick   = 1'b1;
    pushExp(2, 12'h777);
    @(negedge clk);
    sampleTick = 1'b0;
    @(negedge clk);
    sampleTick = 1'b1;
    pushExp(2, 12'h777);
    @(negedge clk);
    sampleTick = 1'b0;
    @(negedge clk);
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
    repeat (16) @(negedge clk);
    check(writeCount == expCount, "R7 pending served once", writeCount, expCount);

    // reset mid-run restarts the pointer at 0 (R1)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    shPtr = 0;
    @(negedge clk);
    check(tapOut == '0, "R1 tapOut after rerun reset", int'(tapOut), 0);
    check(filtIn == '0, "R1 filtIn after rerun reset", int'(filtIn), 0);
    for (int s = 0; s < 5; s++) sendSample(s * 4 + 1, 12'h200 + s, 1'b0);

    repeat (5) @(negedge clk);
    check(qAddr.size() == 0, "R2 all expected writes seen", qAddr.size(), 0);
    check(writeCount == expCount, "R2 one write per tick", writeCount, expCount);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

endmodule